// File: doc/BRIEF.md
# AC'97 Command Slot Decoder

This block is the receive side of the codec end of an AC'97 link. It watches the serial output stream from the controller, one bit per bit clock. It finds each frame from the rising edge of the frame sync, collects the 16-bit tag and the 20-bit slots that follow it, and uses the tag's valid flags to decide which slots to act on.

Slot 1 carries a command: a read/write flag and a 7-bit byte index. Slot 2 carries write data. Together they read or write a file of 64 16-bit registers. Only even byte locations exist. An odd index reaches the even register just below it. Read results leave on a parallel interface as a one-cycle pulse carrying the index and the data. The left and right playback samples from slots 3 and 4 are presented on their own outputs, each with a one-cycle valid strobe. Nothing is returned on the serial input stream.

Top module: `ac97_cmd_slot_rx`

## Requirements
- R1: The first rising `clk` edge at which `sync_i` is 1, after it was 0 at the previous edge, samples frame bit 0 (tag bit 15). Bits arrive MSB first: 16 tag bits, then 20-bit slots, so that slot k ends at frame bit 15+20k. A new rising sync restarts alignment at any time, including partway through a frame.
- R2: Tag bit 15 is frame-valid. Tag bits 14, 13, 12 and 11 mark slots 1, 2, 3 and 4 as valid.
- R3: Slot 1 bit 19 selects the operation (1 = read, 0 = write). Bits 18:12 give the 7-bit index. Bits 11:0 have no effect.
- R4: A write stores slot 2 bits 19:4 into the register the index selects. Slot 2 bits 3:0 have no effect.
- R5: A write commits only when tag bits 15, 14 and 13 are all 1. If any of them is 0, no register changes.
- R6: A read needs only tag bit 14. `rd_valid_o` is 1 for exactly the one cycle after the edge that samples frame bit 55. In that cycle `rd_index_o` shows the slot 1 index and `rd_data_o` shows the register contents. With tag bit 14 clear there is no pulse.
- R7: An odd index acts on the register of the even index below it, for both reads and writes (01h reads 00h).
- R8: All 64 registers are separately writable and readable, and each resets to 0000h.
- R9: When tag bit 12 is 1, slot 3's 20 bits appear on `pcm_left_o`, with `pcm_left_valid_o` high for the one cycle after the edge that samples frame bit 75. Tag bit 11 and slot 4 drive `pcm_right_o` and `pcm_right_valid_o` the same way after frame bit 95. An invalid slot leaves its output unchanged and gives no strobe.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every signal is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller |
| sdo_i | input | 1 | Serial frame data from the controller |
| rd_valid_o | output | 1 | One-cycle read-return strobe |
| rd_index_o | output | 7 | Index of the returned read, as sent |
| rd_data_o | output | 16 | Register contents returned by the read |
| pcm_left_o | output | 20 | Latest valid left playback sample |
| pcm_left_valid_o | output | 1 | Strobe for a new left sample |
| pcm_right_o | output | 20 | Latest valid right playback sample |
| pcm_right_valid_o | output | 1 | Strobe for a new right sample |

## Verification
A table of command frames is driven through the decoder. It includes writes with full valid flags, and writes each missing exactly one of the three flags they need. Comparing the next read shows which flag gates the commit. Reads are made with and without frame-valid, and with slot 1 invalid, and the return bit position is recorded. Even/odd index pairs, non-zero reserved bits and writes to neighbouring registers separate aliasing, ignored bits and register independence. Directed frames then cover the reset values, one playback slot valid at a time, and a frame cut short and followed by a fresh sync, which shows that a half-received command never commits and that alignment restarts.

// File: rtl/ac97_cmd_pkg.sv
`timescale 1ns/1ps
package ac97_cmd_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int FRAME_BITS = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int REG_W      = 16;
  localparam int IDX_W      = 7;
  localparam int ADDR_W     = IDX_W - 1;
  localparam int NUM_REGS   = 2 ** ADDR_W;
  // tag flags kept: frame, slot1, slot2, slot3, slot4 (tag bits 15..11)
  localparam int FLAG_W     = 5;

  typedef struct packed {
    logic             rd;
    logic [IDX_W-1:0] idx;
  } cmd_t;

  typedef logic [POS_W-1:0] pos_t;

  function automatic pos_t slot_last_pos(input int k);
    return pos_t'(TAG_W + SLOT_W * k - 1);
  endfunction
endpackage

// File: rtl/ac97_frame_timer.sv
`timescale 1ns/1ps
module ac97_frame_timer
  import ac97_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic bit_act_o,
  output pos_t bit_pos_o
);
  logic sync_q;
  logic run_q, run_d;
  pos_t cnt_q, cnt_d;
  logic realign;

  always_comb begin
    realign   = sync_i & ~sync_q;
    bit_act_o = realign | run_q;
    bit_pos_o = realign ? '0 : cnt_q;
    run_d     = run_q;
    cnt_d     = cnt_q;
    if (realign) begin
      run_d = 1'b1;
      cnt_d = pos_t'(1);
    end else if (run_q) begin
      if (cnt_q == pos_t'(FRAME_BITS - 1)) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_i;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
    end
  end

  // R1: after a sync rise the next bit is frame bit 1
  a_r1_realign_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !sync_q) |=> (bit_act_o && bit_pos_o == pos_t'(1)));
endmodule

// File: rtl/ac97_slot_deser.sv
`timescale 1ns/1ps
module ac97_slot_deser
  import ac97_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_act_i,
  input  pos_t              bit_pos_i,
  input  logic              sd_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [SLOT_W-1:0] word_o
);
  logic [SLOT_W-2:0] sh_q, sh_d;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    word_o  = {sh_q, sd_i};
    sh_d    = bit_act_i ? word_o[SLOT_W-2:0] : sh_q;
    flags_d = flags_o;
    if (bit_act_i && bit_pos_i == pos_t'(TAG_W - 1))
      flags_d = word_o[TAG_W-1 -: FLAG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      flags_o <= '0;
    end else begin
      sh_q    <= sh_d;
      flags_o <= flags_d;
    end
  end
endmodule

// File: rtl/ac97_cmd_regfile.sv
`timescale 1ns/1ps
module ac97_cmd_regfile
  import ac97_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  logic [REG_W-1:0] cells [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    logic             hit;
    logic [REG_W-1:0] q;
    assign hit      = wr_en_i && (wr_addr_i == ADDR_W'(g));
    assign cells[g] = q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data_i;
    end
  end

  assign rd_data_o = cells[rd_addr_i];

  // R4: a write is visible in its cell on the next cycle
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> cells[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/ac97_cmd_slot_rx.sv
`timescale 1ns/1ps
module ac97_cmd_slot_rx
  import ac97_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              sdo_i,
  output logic              rd_valid_o,
  output logic [IDX_W-1:0]  rd_index_o,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [SLOT_W-1:0] pcm_left_o,
  output logic              pcm_left_valid_o,
  output logic [SLOT_W-1:0] pcm_right_o,
  output logic              pcm_right_valid_o
);
  localparam pos_t S1_LAST = slot_last_pos(1);
  localparam pos_t S2_LAST = slot_last_pos(2);
  localparam pos_t S3_LAST = slot_last_pos(3);
  localparam pos_t S4_LAST = slot_last_pos(4);
  localparam int F_FRAME = 4, F_S1 = 3, F_S2 = 2, F_S3 = 1, F_S4 = 0;

  logic              bit_act;
  pos_t              bit_pos;
  logic [FLAG_W-1:0] flags;
  logic [SLOT_W-1:0] word;
  logic              end_s1, end_s2, end_s3, end_s4;
  cmd_t              cmd_q, cmd_d;
  logic              wr_en, rd_fire, left_fire, right_fire;
  logic [REG_W-1:0]  rf_rdata;
  logic [IDX_W-1:0]  rd_index_d;
  logic [REG_W-1:0]  rd_data_d;
  logic [SLOT_W-1:0] left_d, right_d;

  ac97_frame_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .bit_act_o (bit_act),
    .bit_pos_o (bit_pos)
  );

  ac97_slot_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_act_i (bit_act),
    .bit_pos_i (bit_pos),
    .sd_i      (sdo_i),
    .flags_o   (flags),
    .word_o    (word)
  );

  ac97_cmd_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (cmd_q.idx[IDX_W-1:1]),
    .wr_data_i (word[SLOT_W-1 -: REG_W]),
    .rd_addr_i (cmd_q.idx[IDX_W-1:1]),
    .rd_data_o (rf_rdata)
  );

  always_comb begin
    end_s1 = bit_act && (bit_pos == S1_LAST);
    end_s2 = bit_act && (bit_pos == S2_LAST);
    end_s3 = bit_act && (bit_pos == S3_LAST);
    end_s4 = bit_act && (bit_pos == S4_LAST);

    cmd_d = cmd_q;
    if (end_s1) cmd_d = '{rd: word[SLOT_W-1], idx: word[SLOT_W-2 -: IDX_W]};

    wr_en = end_s2 && !cmd_q.rd && flags[F_FRAME] && flags[F_S1] && flags[F_S2];
    rd_fire    = end_s2 && cmd_q.rd && flags[F_S1];
    left_fire  = end_s3 && flags[F_S3];
    right_fire = end_s4 && flags[F_S4];

    rd_index_d = rd_fire ? cmd_q.idx : rd_index_o;
    rd_data_d  = rd_fire ? rf_rdata  : rd_data_o;
    left_d     = left_fire  ? word : pcm_left_o;
    right_d    = right_fire ? word : pcm_right_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q             <= '0;
      rd_valid_o        <= 1'b0;
      rd_index_o        <= '0;
      rd_data_o         <= '0;
      pcm_left_o        <= '0;
      pcm_left_valid_o  <= 1'b0;
      pcm_right_o       <= '0;
      pcm_right_valid_o <= 1'b0;
    end else begin
      cmd_q             <= cmd_d;
      rd_valid_o        <= rd_fire;
      rd_index_o        <= rd_index_d;
      rd_data_o         <= rd_data_d;
      pcm_left_o        <= left_d;
      pcm_left_valid_o  <= left_fire;
      pcm_right_o       <= right_d;
      pcm_right_valid_o <= right_fire;
    end
  end

  // R6: read return is a single-cycle pulse
  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);
  // R6: read return follows the last bit of slot 2
  a_r6_rd_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(bit_act && bit_pos == S2_LAST));
  // R9: samples hold between strobes
  a_r9_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_left_valid_o |-> $stable(pcm_left_o));
  a_r9_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_right_valid_o |-> $stable(pcm_right_o));
endmodule

// File: tb/ac97_cmd_slot_rx_tb_top.sv
`timescale 1ns/1ps
module ac97_cmd_slot_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, sync_i, sdo_i;
  logic        rd_valid_o, pcm_left_valid_o, pcm_right_valid_o;
  logic [6:0]  rd_index_o;
  logic [15:0] rd_data_o;
  logic [19:0] pcm_left_o, pcm_right_o;

  int n_checks = 0;
  int n_errors = 0;
  int rd_cnt, rd_bit, l_cnt, l_bit, r_cnt, r_bit;
  logic [6:0]  rd_idx;
  logic [15:0] rd_dat;
  logic [19:0] l_dat, r_dat;

  always #2.5 clk = ~clk;

  ac97_cmd_slot_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sdo_i(sdo_i),
    .rd_valid_o(rd_valid_o), .rd_index_o(rd_index_o), .rd_data_o(rd_data_o),
    .pcm_left_o(pcm_left_o), .pcm_left_valid_o(pcm_left_valid_o),
    .pcm_right_o(pcm_right_o), .pcm_right_valid_o(pcm_right_valid_o)
  );

  // {tag, slot1, slot2, expect_read, expect_data}
  localparam int NV = 17;
  localparam logic [72:0] VEC [NV] = '{
    {16'hE000, 20'h02000, 20'hA5A5F, 1'b0, 16'h0000}, // R4 write 02h, reserved bits set
    {16'h4000, 20'h82FFF, 20'h00000, 1'b1, 16'hA5A5}, // R6 R3 read without frame-valid
    {16'hE000, 20'h03000, 20'h12340, 1'b0, 16'h0000}, // R7 write odd 03h
    {16'h4000, 20'h82000, 20'h00000, 1'b1, 16'h1234}, // R7 read 02h
    {16'hC000, 20'h83000, 20'h00000, 1'b1, 16'h1234}, // R7 read 03h
    {16'h6000, 20'h7E000, 20'hBEEF0, 1'b0, 16'h0000}, // R5 no frame-valid
    {16'hC000, 20'hFE000, 20'h00000, 1'b1, 16'h0000}, // R5 read 7Eh
    {16'hA000, 20'h7E000, 20'hBEEF0, 1'b0, 16'h0000}, // R5 no slot1 valid
    {16'hC000, 20'h7E000, 20'hCAFE0, 1'b0, 16'h0000}, // R5 no slot2 valid
    {16'hC000, 20'hFE000, 20'h00000, 1'b1, 16'h0000}, // R5 read 7Eh
    {16'hE000, 20'h7E000, 20'hBEEF0, 1'b0, 16'h0000}, // R4 commit 7Eh
    {16'hC000, 20'hFF000, 20'h00000, 1'b1, 16'hBEEF}, // R7 read 7Fh
    {16'h8000, 20'h82000, 20'h00000, 1'b0, 16'h0000}, // R6 slot1 invalid: no pulse
    {16'hC000, 20'h80000, 20'h00000, 1'b1, 16'h0000}, // R8 00h still reset value
    {16'hE000, 20'h00000, 20'hFFFF0, 1'b0, 16'h0000}, // R8 write 00h
    {16'hC000, 20'h82000, 20'h00000, 1'b1, 16'h1234}, // R8 02h independent
    {16'hC000, 20'h81000, 20'h00000, 1'b1, 16'hFFFF}  // R7 R8 read 01h
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sample(input int i);
    if (rd_valid_o)        begin rd_cnt++; rd_bit = i; rd_idx = rd_index_o; rd_dat = rd_data_o; end
    if (pcm_left_valid_o)  begin l_cnt++;  l_bit  = i; l_dat  = pcm_left_o;  end
    if (pcm_right_valid_o) begin r_cnt++;  r_bit  = i; r_dat  = pcm_right_o; end
  endtask

  task automatic run_frame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4,
                           input int nbits);
    logic [255:0] fr;
    fr = {tag, s1, s2, s3, s4, 160'd0};
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); sync_i = 1'b0; sdo_i = 1'b0;
    end
    rd_cnt = 0; l_cnt = 0; r_cnt = 0; rd_bit = -1; l_bit = -1; r_bit = -1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sample(i);
      sync_i = (i < 16);
      sdo_i  = fr[255-i];
    end
    for (int i = nbits; i < nbits + 4; i++) begin
      @(negedge clk);
      sample(i);
      sync_i = 1'b0; sdo_i = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_i = 1'b0; sdo_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10 outputs during reset
    chk("R10 rd_valid", 32'(rd_valid_o), 0);
    chk("R10 pcm_left", 32'(pcm_left_o), 0);
    chk("R10 pcm_right", 32'(pcm_right_o), 0);
    chk("R10 strobes", 32'({pcm_left_valid_o, pcm_right_valid_o, rd_data_o}), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][72:57], VEC[v][56:37], VEC[v][36:17], 20'h0, 20'h0, 256);
      if (VEC[v][16]) begin
        chk($sformatf("R6 vec%0d read count", v), 32'(rd_cnt), 1);
        chk($sformatf("R6 vec%0d read bit", v), 32'(rd_bit), 56);
        chk($sformatf("R3 vec%0d index", v), 32'(rd_idx), 32'(VEC[v][55:49]));
        chk($sformatf("R4 vec%0d data", v), 32'(rd_dat), 32'(VEC[v][15:0]));
      end else begin
        chk($sformatf("R6 vec%0d no read", v), 32'(rd_cnt), 0);
      end
    end

    // R9 both playback slots valid
    run_frame(16'h9800, 20'h0, 20'h0, 20'h12345, 20'hABCDE, 256);
    chk("R9 left count", 32'(l_cnt), 1);
    chk("R9 left bit", 32'(l_bit), 76);
    chk("R9 left data", 32'(l_dat), 32'h12345);
    chk("R9 right count", 32'(r_cnt), 1);
    chk("R9 right bit", 32'(r_bit), 96);
    chk("R9 right data", 32'(r_dat), 32'hABCDE);

    // R9 R2 slots marked invalid: no strobe, outputs held
    run_frame(16'h8000, 20'h0, 20'h0, 20'h55555, 20'h66666, 256);
    chk("R9 invalid left strobe", 32'(l_cnt), 0);
    chk("R9 invalid right strobe", 32'(r_cnt), 0);
    chk("R9 left held", 32'(pcm_left_o), 32'h12345);
    chk("R9 right held", 32'(pcm_right_o), 32'hABCDE);

    // R2 only slot 3 valid
    run_frame(16'h9000, 20'h0, 20'h0, 20'h0F0F0, 20'h11111, 256);
    chk("R2 left only data", 32'(pcm_left_o), 32'h0F0F0);
    chk("R2 left only right strobe", 32'(r_cnt), 0);
    chk("R2 right untouched", 32'(pcm_right_o), 32'hABCDE);

    // R1 frame cut after 40 bits, then a fresh sync realigns
    run_frame(16'hE000, 20'h10000, 20'h55550, 20'h0, 20'h0, 40);
    chk("R1 cut frame no read", 32'(rd_cnt), 0);
    run_frame(16'hC000, 20'h90000, 20'h0, 20'h0, 20'h0, 256);
    chk("R1 realigned read count", 32'(rd_cnt), 1);
    chk("R1 realigned read bit", 32'(rd_bit), 56);
    chk("R1 cut write not committed", 32'(rd_dat), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule